// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address that a synchronous memory uses during a four-beat burst. An external start address is captured into a register through one of two active-low address strobes. The two strobes differ in how chip enable qualifies them. After the capture, an active-low advance input steps a two-bit beat counter. Only the two lowest address bits follow that counter. The upper bits stay as they were loaded.

A static order input selects how the low bits are formed. In linear mode they are the start value plus the beat count, modulo four. In interleaved mode they are the start value XOR the beat count. When advance is inactive the burst is suspended and the same address is presented again. After four steps the counter wraps back to the start value. Two registered flags report whether the last clock edge performed a load or a step.

Top module: `burst_addr_seq`

## Requirements
- R1: With chipEnN low and ctrlStrobeN low at a rising edge, addrIn is captured, and addrOut equals addrIn from that edge on.
- R2: With chipEnN low and procStrobeN low at a rising edge, addrIn is captured in the same way as in R1.
- R3: While chipEnN is high, procStrobeN has no effect. With ctrlStrobeN high, the edge behaves as an advance or a hold according to advanceN.
- R4: With ctrlStrobeN low and chipEnN high, the edge is a deselect: no load and no step take place, so addrOut and the beat count hold.
- R5: advanceN is active low. A non-load, non-deselect edge with advanceN high leaves addrOut unchanged (burst suspend).
- R6: With orderSel low (linear), addrOut[1:0] equals (start + count) mod 4. A start of 01 gives 01, 10, 11, 00.
- R7: With orderSel high (interleaved), addrOut[1:0] equals start XOR count. A start of 01 gives 01, 00, 11, 10.
- R8: After four steps the low bits return to the start value.
- R9: A load takes priority over an advance in the same cycle and resets the beat count to zero.
- R10: addrOut[ADDR_W-1:2] changes only on a load.
- R11: After reset, addrOut is zero, the beat count is zero, and loadFlag and stepFlag are low.
- R12: loadFlag is high for the cycle after a load edge. stepFlag is high for the cycle after a step edge. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| procStrobeN | input | 1 | Processor address strobe, active low, gated by chip enable |
| chipEnN | input | 1 | Chip enable, active low |
| advanceN | input | 1 | Burst advance, active low |
| orderSel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | External start address |
| addrOut | output | ADDR_W | Current internal word address |
| loadFlag | output | 1 | Last edge loaded a new address |
| stepFlag | output | 1 | Last edge stepped the burst |

## Verification
Directed bursts start from each of the four low-bit values in both orders. Each burst has a suspend in the middle and runs until the counter wraps. This separates the adder path from the XOR path: the two agree only for starts 00 and 10 on odd counts. It also shows that a suspend does not disturb the wrap. Random cycles then mix both strobes with both chip-enable levels and with advance. This tells apart a processor strobe that is ignored, a controller-strobe deselect that freezes the counter, and a true load. A directed load-with-advance cycle exposes any priority inversion.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Per-edge action decided by control and consumed by the datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic hold;
  } seqStrobe_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic       ctrlStrobeN,
  input  logic       procStrobeN,
  input  logic       chipEnN,
  input  logic       advanceN,
  output seqStrobe_t strobes
);

  logic chipOn;
  logic anyStrobe;
  logic deselect;

  always_comb begin
    chipOn    = !chipEnN;
    anyStrobe = !ctrlStrobeN || !procStrobeN;
    // Controller strobe while disabled freezes everything
    deselect  = chipEnN && !ctrlStrobeN;
    strobes.load    = chipOn && anyStrobe;
    strobes.advance = !strobes.load && !deselect && !advanceN;
    strobes.hold    = !strobes.load && !strobes.advance;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              loadFlag,
  output logic              stepFlag
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     baseQ;
  logic [BURST_BITS-1:0] cntQ;
  logic [BURST_BITS-1:0] linLow;
  logic [BURST_BITS-1:0] xorLow;
  logic [BURST_BITS-1:0] lowSel;
  order_e                orderMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      cntQ     <= '0;
      loadFlag <= 1'b0;
      stepFlag <= 1'b0;
    end else begin
      loadFlag <= strobes.load;
      stepFlag <= strobes.advance;
      if (strobes.load) begin
        baseQ <= addrIn;
        cntQ  <= '0;
      end else if (strobes.advance) begin
        cntQ  <= cntQ + 1'b1;
      end
    end
  end

  // Interleaved order: one XOR lane per burst bit
  for (genvar i = 0; i < BURST_BITS; i++) begin : g_xorLane
    assign xorLow[i] = baseQ[i] ^ cntQ[i];
  end

  assign linLow    = baseQ[BURST_BITS-1:0] + cntQ;
  assign orderMode = order_e'(orderSel);

  always_comb begin
    case (orderMode)
      ORDER_XOR: lowSel = xorLow;
      default:   lowSel = linLow;
    endcase
  end

  assign addrOut = {baseQ[ADDR_W-1 -: HI_W], lowSel};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlStrobeN,
  input  logic              procStrobeN,
  input  logic              chipEnN,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              loadFlag,
  output logic              stepFlag
);

  seqStrobe_t strobes;

  burst_ctrl ctrl_i (
    .ctrlStrobeN (ctrlStrobeN),
    .procStrobeN (procStrobeN),
    .chipEnN     (chipEnN),
    .advanceN    (advanceN),
    .strobes     (strobes)
  );

  burst_datapath #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .addrOut  (addrOut),
    .loadFlag (loadFlag),
    .stepFlag (stepFlag)
  );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlStrobeN,
  input logic              procStrobeN,
  input logic              chipEnN,
  input logic              advanceN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic              loadFlag,
  input logic              stepFlag
);

  logic loadReq;
  assign loadReq = !chipEnN && (!ctrlStrobeN || !procStrobeN);

  // R1 R2 R9: any qualified strobe captures addrIn with count zero
  a_r1_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> (addrOut == $past(addrIn)) && loadFlag && !stepFlag);

  // R3: processor strobe with chip disabled and no advance changes nothing
  a_r3_proc_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (chipEnN && !procStrobeN && ctrlStrobeN && advanceN) |=> $stable(addrOut) && !loadFlag);

  // R4: controller strobe with chip disabled is a deselect
  a_r4_deselect_hold: assert property (@(posedge clk) disable iff (!rstN)
    (chipEnN && !ctrlStrobeN) |=> $stable(addrOut) && !loadFlag && !stepFlag);

  // R5: advance inactive and no load suspends the burst
  a_r5_suspend: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && advanceN) |=> $stable(addrOut) && !stepFlag);

  // R10: upper bits move only on a load
  a_r10_upper_stable: assert property (@(posedge clk) disable iff (!rstN)
    !loadReq |=> $stable(addrOut[ADDR_W-1:BURST_BITS]));

  // R12: flags are mutually exclusive
  a_r12_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadFlag, stepFlag}));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BURST_BITS (BURST_BITS)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlStrobeN (ctrlStrobeN),
  .procStrobeN (procStrobeN),
  .chipEnN     (chipEnN),
  .advanceN    (advanceN),
  .addrIn      (addrIn),
  .addrOut     (addrOut),
  .loadFlag    (loadFlag),
  .stepFlag    (stepFlag)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ctrlStrobeN = 1'b1;
  logic              procStrobeN = 1'b1;
  logic              chipEnN = 1'b1;
  logic              advanceN = 1'b1;
  logic              orderSel = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] addrOut;
  logic              loadFlag;
  logic              stepFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference state
  logic [ADDR_W-1:0] mBase = '0;
  int                mCnt = 0;
  bit                mLoad = 0;
  bit                mStep = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BURST_BITS(2)) dut_i (
    .clk (clk), .rstN (rstN), .ctrlStrobeN (ctrlStrobeN),
    .procStrobeN (procStrobeN), .chipEnN (chipEnN), .advanceN (advanceN),
    .orderSel (orderSel), .addrIn (addrIn), .addrOut (addrOut),
    .loadFlag (loadFlag), .stepFlag (stepFlag)
  );

  function automatic logic [ADDR_W-1:0] refAddr(logic [ADDR_W-1:0] b, int c, bit ilv);
    int lo;
    if (ilv) lo = int'(b[1:0]) ^ c;
    else     lo = (int'(b[1:0]) + c) % 4;
    return {b[ADDR_W-1:2], 2'(lo)};
  endfunction

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Apply inputs, take one edge, update the reference, then compare
  task automatic step(bit c, bit p, bit ce, bit adv, logic [ADDR_W-1:0] a, string tag);
    bit ld, des, st;
    ctrlStrobeN = c; procStrobeN = p; chipEnN = ce; advanceN = adv; addrIn = a;
    ld  = !ce && (!c || !p);
    des = ce && !c;
    st  = !ld && !des && !adv;
    @(posedge clk);
    if (ld) begin mBase = a; mCnt = 0; end
    else if (st) mCnt = (mCnt + 1) % 4;
    mLoad = ld; mStep = st;
    #1;
    check(tag, addrOut, refAddr(mBase, mCnt, orderSel));
    check("R12", ADDR_W'({loadFlag, stepFlag}), ADDR_W'({mLoad, mStep}));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [ADDR_W-1:0] a;
    logic [1:0] linRef [4];
    logic [1:0] xorRef [4];
    linRef = '{2'b01, 2'b10, 2'b11, 2'b00};
    xorRef = '{2'b01, 2'b00, 2'b11, 2'b10};
    seed = 32'd1234;
    void'($urandom(seed));

    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R11", addrOut, '0);
    check("R11", ADDR_W'({loadFlag, stepFlag}), '0);
    rstN = 1'b1;

    // R6 R7 R8: every start in both orders, with a suspend mid-burst
    for (int m = 0; m < 2; m++) begin
      orderSel = m[0];
      for (int s = 0; s < 4; s++) begin
        a = {ADDR_W'($urandom) >> 2, 2'(s)};
        a[1:0] = 2'(s);
        step(1, 0, 0, 1, a, m ? "R7" : "R6");
        for (int k = 1; k < 4; k++) begin
          if (k == 2) step(1, 1, 0, 1, '0, "R5");
          step(1, 1, 0, 0, '0, m ? "R7" : "R6");
          if (s == 1)
            check(m ? "R7" : "R6", ADDR_W'(addrOut[1:0]),
                  ADDR_W'(m ? xorRef[k] : linRef[k]));
          check("R10", addrOut >> 2, a >> 2);
        end
        step(1, 1, 0, 0, '0, "R8");
        check("R8", addrOut, a);
      end
    end

    // R9: load and advance in the same cycle
    orderSel = 1'b0;
    step(0, 1, 0, 0, 20'h12341, "R1");
    step(1, 1, 0, 0, '0, "R6");
    step(1, 0, 0, 0, 20'hABCD2, "R9");
    check("R9", addrOut, 20'hABCD2);
    // R3: ignored processor strobe while an advance proceeds
    step(1, 0, 1, 0, 20'h55555, "R3");
    check("R3", addrOut, 20'hABCD3);
    // R4: deselect freezes despite advance
    step(0, 1, 1, 0, 20'h77777, "R4");
    check("R4", addrOut, 20'hABCD3);

    // Random mix, half the run in each order
    for (int i = 0; i < 3000; i++) begin
      bit c, p, ce, adv;
      string tag;
      c   = ($urandom % 4) == 0;
      p   = ($urandom % 4) == 0;
      c   = !c; p = !p;
      ce  = ($urandom % 3) == 0;
      adv = ($urandom % 3) == 0;
      if (i == 1500) begin
        orderSel = 1'b1;
        step(1, 0, 0, 1, ADDR_W'($urandom), "R2");
      end
      if (!ce && !c)      tag = "R1";
      else if (!ce && !p) tag = "R2";
      else if (ce && !c)  tag = "R4";
      else if (ce && !p)  tag = "R3";
      else if (adv)       tag = "R5";
      else                tag = orderSel ? "R7" : "R6";
      step(c, p, ce, adv, ADDR_W'($urandom), tag);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule